// File: doc/BRIEF.md
# Prioritised Host Interrupt Notifier

This block turns event flags raised by independent producers into interrupts toward a host processor. Four event kinds are tracked, each with its own pending bit: a real-time tick, a display-write acknowledge, a button change and a diagnostic note. When one or more are pending, the block picks the most urgent and loads that event's vector number into a single byte-wide output buffer. A loaded buffer drives an active-low ready line, and that line is the host's interrupt.

The button-change event carries one extra byte: the button pattern captured with the most recent button event. That byte goes through the same buffer, and only after the host has emptied the buffer of the vector. The output side behaves as a valid/ready stream. The buffer-full flag is the valid. The host read strobe is the ready, and it counts only while the buffer is full. A strobe while the buffer is empty is dropped. A byte is never replaced while it is unread, so the host applies back-pressure just by not reading. The block loads a new byte only in a cycle that starts with the buffer empty. One idle cycle therefore separates a host read from the next load.

Top module: `host_irq_notifier`

## Requirements
- R1: After reset the pending bits are 0, the buffer-full flag is 0 and the ready output is 1.
- R2: A 1 on bit i of the event-set input (bit 0 tick, 1 acknowledge, 2 button, 3 diagnostic) makes pending bit i read 1 on the next cycle, without disturbing the other bits.
- R3: A byte is loaded only in a cycle that begins with the buffer empty. While the buffer is full and not read, the flag and the data both stay unchanged.
- R4: The first byte sent for an event is its vector. The defaults are tick 0x10, acknowledge 0x11, button 0x12 and diagnostic 0x13.
- R5: When several bits are pending, they are served lowest bit first: tick, then acknowledge, then button, then diagnostic.
- R6: Tick, acknowledge and diagnostic send only their vector. The button event sends one payload byte after its vector. That byte is the pattern present on the button input in the cycle of the most recent button set.
- R7: An event is fully sent (vector, and payload if any) before any other vector is loaded.
- R8: A pending bit clears in the cycle its vector is loaded. If the same bit is set in that cycle, the bit stays 1.
- R9: A host read strobe while the buffer is full clears the flag on the next cycle. A strobe while the buffer is empty has no effect.
- R10: The ready output is always the inverse of the buffer-full flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_set | input | 4 | One-cycle set pulses, one bit per event kind |
| btn_pattern | input | 8 | Button pattern, captured when evt_set[2] is high |
| host_rd | input | 1 | Host read strobe (stream ready) |
| obuf_data | output | 8 | Output buffer byte |
| obuf_full | output | 1 | Buffer holds an unread byte (stream valid) |
| rdy_n | output | 1 | Active-low host interrupt, inverse of obuf_full |
| pending | output | 4 | Pending event bits |

## Verification
The assertions assume the host raises its read strobe only on purpose. A strobe on an empty buffer has to be tolerated and dropped, not treated as an error. They also assume set pulses can arrive on any cycle, including the cycle that clears the same bit. The random stimulus therefore draws set pulses and read strobes freely, with read strobes also falling on empty-buffer cycles. It keeps set pulses sparse so that the queue drains, and directed phases force same-cycle set-and-clear and a tick arriving while a button payload is still outstanding.

// File: rtl/hin_pkg.sv
package hin_pkg;
  localparam int NUM_EVT  = 4;
  localparam int BYTE_W   = 8;
  localparam int EVT_IDXW = $clog2(NUM_EVT);
  localparam int EVT_TICK = 0;
  localparam int EVT_ACK  = 1;
  localparam int EVT_BTN  = 2;
  localparam int EVT_DIAG = 3;

  typedef enum logic {ST_SCAN, ST_PAYLOAD} hin_state_e;
endpackage

// File: rtl/hin_pending.sv
module hin_pending #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~clr_i) | set_i;
  end

  assign pend_o = pend_q;

  for (genvar g = 0; g < N; g++) begin : g_chk
    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      set_i[g] |=> pend_q[g]); // R8
    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[g] && !set_i[g]) |=> !pend_q[g]); // R8
  end

  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_i)); // R7
endmodule

// File: rtl/hin_prio_pick.sv
module hin_prio_pick #(
  parameter int N  = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt_o = '0;
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_i[i] && !found) begin
        found    = 1'b1;
        gnt_o[i] = 1'b1;
        idx_o    = IW'(i);
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/hin_mailbox.sv
module hin_mailbox #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wr_byte_i,
  input  logic         rd_i,
  output logic [W-1:0] data_o,
  output logic         full_o
);
  logic         full_q;
  logic [W-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (wr_i && !full_q) begin
      full_q <= 1'b1;
      data_q <= wr_byte_i;
    end else if (rd_i && full_q) begin
      full_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;

  AST_NO_BLIND_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |-> !full_q); // R3
  AST_HOLD_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && !rd_i) |=> (full_q && $stable(data_q))); // R3
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (full_q && rd_i) |=> !full_q); // R9
  AST_IDLE_READ_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_q && rd_i && !wr_i) |=> (!full_q && $stable(data_q))); // R9
endmodule

// File: rtl/host_irq_notifier.sv
module host_irq_notifier
  import hin_pkg::*;
#(
  parameter logic [BYTE_W-1:0] VEC_TICK = 8'h10,
  parameter logic [BYTE_W-1:0] VEC_ACK  = 8'h11,
  parameter logic [BYTE_W-1:0] VEC_BTN  = 8'h12,
  parameter logic [BYTE_W-1:0] VEC_DIAG = 8'h13
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic [BYTE_W-1:0]  btn_pattern,
  input  logic               host_rd,
  output logic [BYTE_W-1:0]  obuf_data,
  output logic               obuf_full,
  output logic               rdy_n,
  output logic [NUM_EVT-1:0] pending
);
  hin_state_e          st_q;
  logic [NUM_EVT-1:0]  pend, gnt, clr;
  logic [EVT_IDXW-1:0] idx;
  logic                any;
  logic [BYTE_W-1:0]   btn_q, vec_byte, wr_byte;
  logic                buf_full, vec_wr, pay_wr, wr_en;

  hin_pending #(.N(NUM_EVT)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(evt_set), .clr_i(clr), .pend_o(pend)
  );

  hin_prio_pick #(.N(NUM_EVT), .IW(EVT_IDXW)) u_pick (
    .req_i(pend), .gnt_o(gnt), .idx_o(idx), .any_o(any)
  );

  always_comb begin
    unique case (idx)
      EVT_IDXW'(EVT_TICK): vec_byte = VEC_TICK;
      EVT_IDXW'(EVT_ACK):  vec_byte = VEC_ACK;
      EVT_IDXW'(EVT_BTN):  vec_byte = VEC_BTN;
      default:             vec_byte = VEC_DIAG;
    endcase
  end

  assign vec_wr  = (st_q == ST_SCAN) && !buf_full && any;
  assign pay_wr  = (st_q == ST_PAYLOAD) && !buf_full;
  assign wr_en   = vec_wr || pay_wr;
  assign wr_byte = pay_wr ? btn_q : vec_byte;
  assign clr     = vec_wr ? gnt : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_SCAN;
      btn_q <= '0;
    end else begin
      if (evt_set[EVT_BTN]) btn_q <= btn_pattern;
      if (vec_wr && gnt[EVT_BTN]) st_q <= ST_PAYLOAD;
      else if (pay_wr)            st_q <= ST_SCAN;
    end
  end

  hin_mailbox #(.W(BYTE_W)) u_mbox (
    .clk(clk), .rst_n(rst_n), .wr_i(wr_en), .wr_byte_i(wr_byte),
    .rd_i(host_rd), .data_o(obuf_data), .full_o(buf_full)
  );

  assign obuf_full = buf_full;
  assign rdy_n     = ~buf_full;
  assign pending   = pend;

  AST_PAYLOAD_FOLLOWS_BTN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ST_PAYLOAD) |-> (buf_full && obuf_data == VEC_BTN)); // R6
  AST_NO_VECTOR_MIDEVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAYLOAD) |-> !vec_wr); // R7
  AST_LOAD_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !rdy_n); // R10
endmodule

// File: tb/host_irq_notifier_test.sv
module host_irq_notifier_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] evt_set = '0;
  logic [7:0] btn_pattern = '0;
  logic       host_rd = 1'b0;
  logic [7:0] obuf_data;
  logic       obuf_full, rdy_n;
  logic [3:0] pending;

  int errors = 0;
  int checks = 0;
  logic [7:0] got[$];

  // reference state built from the requirements
  logic [3:0] m_pend = '0;
  logic       m_full = 1'b0;
  logic [7:0] m_data = '0;
  logic [7:0] m_btn = '0;
  logic       m_pay = 1'b0;

  always #2 clk = ~clk;

  host_irq_notifier uut (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .btn_pattern(btn_pattern),
    .host_rd(host_rd), .obuf_data(obuf_data), .obuf_full(obuf_full),
    .rdy_n(rdy_n), .pending(pending)
  );

  function automatic logic [7:0] vec_of(int k);
    return 8'h10 + 8'(k);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_step(logic [3:0] s, logic r, logic [7:0] b);
    logic [3:0] clr;
    clr = '0;
    if (!m_full && !m_pay && m_pend != 0) begin
      for (int k = 0; k < 4; k++) begin
        if (m_pend[k] && clr == 0) begin
          clr[k] = 1'b1;
          m_data = vec_of(k);
          m_full = 1'b1;
          m_pay  = (k == 2);
        end
      end
    end else if (!m_full && m_pay) begin
      m_data = m_btn;
      m_full = 1'b1;
      m_pay  = 1'b0;
    end else if (r && m_full) begin
      m_full = 1'b0;
    end
    m_pend = (m_pend & ~clr) | s;
    if (s[2]) m_btn = b;
  endtask

  task automatic cycle(logic [3:0] s, logic r, logic [7:0] b);
    evt_set = s; host_rd = r; btn_pattern = b;
    if (r && obuf_full) got.push_back(obuf_data);
    @(negedge clk);
    model_step(s, r, b);
    chk("R9 full", obuf_full, m_full);
    chk("R10 ready", rdy_n, !m_full);
    chk("R2 pending", pending, m_pend);
    if (m_full) chk("R5 data", obuf_data, m_data);
  endtask

  task automatic drain(int n);
    for (int i = 0; i < n; i++) cycle(4'b0, 1'b1, 8'h00);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 pending", pending, 4'h0);
    chk("R1 full", obuf_full, 1'b0);
    chk("R1 ready", rdy_n, 1'b1);

    // R9: read strobe on empty buffer is ignored
    cycle(4'b0, 1'b1, 8'h00);
    chk("R9 idle read", obuf_full, 1'b0);

    // R5 R4 R6: all four at once, button payload A5
    got.delete();
    cycle(4'b1111, 1'b0, 8'hA5);
    chk("R2 all set", pending, 4'hF);
    drain(20);
    chk("R5 count", got.size(), 5);
    if (got.size() == 5) begin
      chk("R4 tick vector", got[0], 8'h10);
      chk("R5 ack second", got[1], 8'h11);
      chk("R5 btn third", got[2], 8'h12);
      chk("R6 btn payload", got[3], 8'hA5);
      chk("R6 diag no payload", got[4], 8'h13);
    end

    // R7: tick arrives while button payload outstanding
    got.delete();
    cycle(4'b0100, 1'b0, 8'h3C);
    cycle(4'b0000, 1'b0, 8'h00);
    cycle(4'b0000, 1'b0, 8'h00);
    chk("R3 held vector", obuf_data, 8'h12);
    cycle(4'b0001, 1'b0, 8'h00);
    cycle(4'b0000, 1'b0, 8'h00);
    chk("R3 still full", obuf_full, 1'b1);
    drain(12);
    chk("R7 count", got.size(), 3);
    if (got.size() == 3) begin
      chk("R7 btn vector", got[0], 8'h12);
      chk("R7 payload before tick", got[1], 8'h3C);
      chk("R7 tick after", got[2], 8'h10);
    end

    // R8: set on the cycle the vector is loaded keeps the bit
    cycle(4'b1000, 1'b0, 8'h00);
    cycle(4'b1000, 1'b0, 8'h00);
    chk("R8 kept pending", pending[3], 1'b1);
    chk("R8 vector loaded", obuf_data, 8'h13);
    drain(10);
    chk("R8 drained", pending, 4'h0);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] s;
      logic [7:0] b;
      s = '0;
      for (int k = 0; k < 4; k++) s[k] = ($urandom % 16) == 0;
      b = 8'($urandom);
      cycle(s, ($urandom % 2) == 1, b);
    end
    drain(30);
    chk("R2 final idle", pending, 4'h0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule